// File: doc/BRIEF.md
# Rate and Loss-Threshold Setting Selector

This block turns the control register contents of a limiting amplifier, together with two rate-select pins, into the settings the amplifier core acts on. It holds twelve 8-bit control registers that are written through a plain write port. From them it produces a 4-bit filter-bandwidth code, a 7-bit loss-of-signal assert-level code with its range bit, an offset-cancel disable flag, an 8-bit threshold-adjust code, a clamped pre-emphasis step count and a one-hot output-amplitude select.

The bandwidth code and the loss-of-signal code each come from one of two sources. A built-in default table holds four entries. A bank of four programmable registers holds the other four. The two pins pick the entry in both cases. An enable bit per code chooses between the table and the bank, and the two enable bits are independent. The pin code for unconnected pins (high, low) selects the fourth entry. This lets a system that uses only the write port tune the settings through the fourth register of each bank.

All outputs are registered. A write or a pin change captured at a clock edge shows on the outputs right after that same edge.

Top module: `rate_los_select`

## Requirements
- R1: While reset is low, every output is 0 and all twelve registers are cleared.
- R2: A write with `wr_en` high and `wr_addr` from 0 to 11 replaces that register with `wr_data`. Addresses 12 to 15 change no register and no output.
- R3: The pins {`rate_pins[1]`,`rate_pins[0]`} pick a slot. 00 picks A, 01 picks B, 11 picks C, and 10 picks D. The bandwidth bank is A=reg 4, B=reg 5, C=reg 6, D=reg 7. The loss bank is A=reg 8, B=reg 9, C=reg 10, D=reg 11.
- R4: When bit 7 of reg 4 is 0, `bw_code` is the default for the slot: A=3, B=7, C=11, D=15. When it is 1, `bw_code` is bits 3:0 of the slot's bandwidth register.
- R5: When bit 7 of reg 8 is 0, `los_code` is the default for the slot: A=20, B=45, C=80, D=110. When it is 1, `los_code` is bits 6:0 of the slot's loss register.
- R6: The two enable bits act independently. Either code can come from its bank while the other comes from its default table.
- R7: `los_hi_range` equals bit 2 of reg 0, and `oc_dis` equals bit 1 of reg 0.
- R8: `th_code` equals reg 1.
- R9: `pe_db` equals bits 3:0 of reg 2 when that value is 8 or less, and 8 otherwise.
- R10: Bits 1:0 of reg 3 drive the one-hot `amp_sel`. 00 gives 001, 01 gives 010, and both 10 and 11 give 100.
- R11: A write and a pin value captured at the same edge both show on the outputs after that edge. With no write and steady pins, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_pins | input | 2 | Rate-select pins, bit 1 and bit 0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 8 | Register write data |
| bw_code | output | 4 | Active filter-bandwidth code |
| los_code | output | 7 | Active loss-of-signal assert code |
| los_hi_range | output | 1 | Loss detector high range |
| oc_dis | output | 1 | Offset cancellation disable |
| th_code | output | 8 | Input threshold adjust code |
| pe_db | output | 4 | Pre-emphasis in 1 dB steps, 0 to 8 |
| amp_sel | output | 3 | One-hot output amplitude select |

## Verification
A register write and a pin change can land on the same edge. The outputs must then reflect both: the new register contents read through the newly selected slot. The bench provokes this by writing a bank register while switching the pins to that register's slot in the same cycle, and it also switches to a different slot while writing. It judges the result one edge later against its own model of the registers and the slot mapping.

// File: rtl/rate_los_select.sv
module rate_los_select #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int NREG = 12,
  parameter int BW_W = 4,
  parameter int LOS_W = 7,
  parameter int PE_W = 4,
  parameter int PE_MAX = 8,
  parameter int BW_BASE = 4,
  parameter int LOS_BASE = 8,
  parameter logic [BW_W-1:0] BW_DEF_A = 4'd3,
  parameter logic [BW_W-1:0] BW_DEF_B = 4'd7,
  parameter logic [BW_W-1:0] BW_DEF_C = 4'd11,
  parameter logic [BW_W-1:0] BW_DEF_D = 4'd15,
  parameter logic [LOS_W-1:0] LOS_DEF_A = 7'd20,
  parameter logic [LOS_W-1:0] LOS_DEF_B = 7'd45,
  parameter logic [LOS_W-1:0] LOS_DEF_C = 7'd80,
  parameter logic [LOS_W-1:0] LOS_DEF_D = 7'd110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate_pins,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [BW_W-1:0]  bw_code,
  output logic [LOS_W-1:0] los_code,
  output logic             los_hi_range,
  output logic             oc_dis,
  output logic [DW-1:0]    th_code,
  output logic [PE_W-1:0]  pe_db,
  output logic [2:0]       amp_sel
);
  localparam int SEL_BIT = DW - 1;

  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];
  logic [1:0] slot;
  logic [BW_W-1:0] bw_dflt, bw_d;
  logic [LOS_W-1:0] los_dflt, los_d;
  logic [PE_W-1:0] pe_raw, pe_d;
  logic [2:0] amp_d;
  logic [1:0] live_q;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regs_d[i] = regs_q[i];
      if (wr_en && int'(wr_addr) == i) regs_d[i] = wr_data;
    end
  end

  assign slot = {rate_pins[1], rate_pins[1] ^ rate_pins[0]};

  always_comb begin
    case (slot)
      2'd0: begin bw_dflt = BW_DEF_A; los_dflt = LOS_DEF_A; end
      2'd1: begin bw_dflt = BW_DEF_B; los_dflt = LOS_DEF_B; end
      2'd2: begin bw_dflt = BW_DEF_C; los_dflt = LOS_DEF_C; end
      default: begin bw_dflt = BW_DEF_D; los_dflt = LOS_DEF_D; end
    endcase
  end

  assign bw_d  = regs_d[BW_BASE][SEL_BIT]  ? regs_d[BW_BASE + int'(slot)][BW_W-1:0]   : bw_dflt;
  assign los_d = regs_d[LOS_BASE][SEL_BIT] ? regs_d[LOS_BASE + int'(slot)][LOS_W-1:0] : los_dflt;

  assign pe_raw = regs_d[2][PE_W-1:0];
  assign pe_d   = (int'(pe_raw) > PE_MAX) ? PE_W'(PE_MAX) : pe_raw;

  always_comb begin
    case (regs_d[3][1:0])
      2'b00:   amp_d = 3'b001;
      2'b01:   amp_d = 3'b010;
      default: amp_d = 3'b100;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      bw_code      <= '0;
      los_code     <= '0;
      los_hi_range <= 1'b0;
      oc_dis       <= 1'b0;
      th_code      <= '0;
      pe_db        <= '0;
      amp_sel      <= '0;
      live_q       <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
      bw_code      <= bw_d;
      los_code     <= los_d;
      los_hi_range <= regs_d[0][2];
      oc_dis       <= regs_d[0][1];
      th_code      <= regs_d[1];
      pe_db        <= pe_d;
      amp_sel      <= amp_d;
      live_q       <= {live_q[0], 1'b1};
    end
  end

  // R9
  pe_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(2) && int'(wr_data[PE_W-1:0]) > PE_MAX) |=> (int'(pe_db) == PE_MAX));

  // R10
  amp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(3) && wr_data[1:0] == 2'b11) |=> (amp_sel == 3'b100));

  // R3
  bank_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q[0] && !wr_en && rate_pins == 2'b10 && regs_q[BW_BASE][SEL_BIT])
      |=> (bw_code == regs_q[BW_BASE + 3][BW_W-1:0]));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q[1] && !$past(wr_en) && $stable(rate_pins) && $past(rate_pins) == rate_pins && $past(rst_n))
      |-> ($stable(bw_code) || !$stable($past(rate_pins))));

  // R11
  hold_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q[0] && !wr_en && $stable(rate_pins))
      |=> ($stable(th_code) && $stable(pe_db) && $stable(amp_sel) && $stable(oc_dis)));
endmodule

// File: tb/rate_los_select_bench.sv
module rate_los_select_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rate_pins = 2'b10;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] bw_code;
  logic [6:0] los_code;
  logic los_hi_range, oc_dis;
  logic [7:0] th_code;
  logic [3:0] pe_db;
  logic [2:0] amp_sel;

  int vecs = 0;
  int errs = 0;
  logic [7:0] m [12];

  always #10 clk = ~clk;

  rate_los_select u_rate_los_select (
    .clk(clk), .rst_n(rst_n), .rate_pins(rate_pins), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .bw_code(bw_code), .los_code(los_code),
    .los_hi_range(los_hi_range), .oc_dis(oc_dis), .th_code(th_code),
    .pe_db(pe_db), .amp_sel(amp_sel)
  );

  function automatic int slot_of(logic [1:0] p);
    case (p)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [3:0] exp_bw(logic [1:0] p);
    int s = slot_of(p);
    if (m[4][7]) return m[4 + s][3:0];
    return 4'(3 + 4 * s);
  endfunction

  function automatic logic [6:0] exp_los(logic [1:0] p);
    int s = slot_of(p);
    logic [6:0] d [4] = '{7'd20, 7'd45, 7'd80, 7'd110};
    if (m[8][7]) return m[8 + s][6:0];
    return d[s];
  endfunction

  task automatic cmp(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d pins=%b", req, act, exp, rate_pins);
    end
  endtask

  task automatic check_all(string tag);
    int pe = (m[2][3:0] > 8) ? 8 : int'(m[2][3:0]);
    int amp = (m[3][1:0] == 2'b00) ? 1 : (m[3][1:0] == 2'b01) ? 2 : 4;
    cmp({tag, " R4 bw"}, bw_code, exp_bw(rate_pins));
    cmp({tag, " R5 los"}, los_code, exp_los(rate_pins));
    cmp({tag, " R7 range"}, los_hi_range, m[0][2]);
    cmp({tag, " R7 ocdis"}, oc_dis, m[0][1]);
    cmp({tag, " R8 th"}, th_code, m[1]);
    cmp({tag, " R9 pe"}, pe_db, pe);
    cmp({tag, " R10 amp"}, amp_sel, amp);
  endtask

  task automatic step(logic we, logic [3:0] a, logic [7:0] d, logic [1:0] p);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; rate_pins = p;
    if (we && a < 12) m[a] = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #4000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    cmp("R1 bw", bw_code, 0); cmp("R1 los", los_code, 0);
    cmp("R1 amp", amp_sel, 0); cmp("R1 th", th_code, 0);
    rst_n = 1'b1;
    step(1'b0, 4'd0, 8'd0, 2'b10);
    check_all("R1 post");
    // R3 R4 R5 R6: bank contents, then sweep enables and pins
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 4'(5 + i), 8'(8'h50 + 8'(13 * i)), 2'b10);
      step(1'b1, 4'(9 + i), 8'(8'h81 + 8'(29 * i)), 2'b10);
    end
    for (int en = 0; en < 4; en++) begin
      step(1'b1, 4'd4, {en[0], 3'b0, 4'(9 + en)}, 2'b00);
      step(1'b1, 4'd8, {en[1], 7'(100 + en)}, 2'b00);
      for (int p = 0; p < 4; p++) begin
        step(1'b0, 4'd0, 8'd0, 2'(p));
        check_all($sformatf("R3 R6 en=%0d", en));
      end
    end
    // R7 R8
    for (int v = 0; v < 8; v++) begin
      step(1'b1, 4'd0, 8'(v), 2'b01);
      check_all("R7");
    end
    for (int v = 0; v < 256; v += 37) begin
      step(1'b1, 4'd1, 8'(v), 2'b11);
      check_all("R8");
    end
    // R9 R10 exhaustive
    for (int v = 0; v < 16; v++) begin
      step(1'b1, 4'd2, 8'(8'hA0 | v), 2'b00);
      check_all("R9");
    end
    for (int v = 0; v < 4; v++) begin
      step(1'b1, 4'd3, 8'(8'hF0 | v), 2'b10);
      check_all("R10");
    end
    // R2 out-of-range writes ignored, checked through all slots
    step(1'b1, 4'd4, 8'h80, 2'b00);
    step(1'b1, 4'd8, 8'h80, 2'b00);
    for (int a = 12; a < 16; a++) begin
      step(1'b1, 4'(a), 8'h3C, 2'b00);
      for (int p = 0; p < 4; p++) begin
        step(1'b0, 4'd0, 8'd0, 2'(p));
        check_all("R2 ignored");
      end
    end
    // R11 write and pin change in the same cycle
    for (int p = 0; p < 4; p++) begin
      step(1'b1, 4'(4 + slot_of(2'(p))), 8'(8'h80 * (slot_of(2'(p)) == 0) + 8'(p + 2)), 2'(p));
      check_all("R11 same slot");
      step(1'b1, 4'(8 + slot_of(2'(p))), 8'(8'h80 * (slot_of(2'(p)) == 0) + 8'(40 + p)), 2'(3 - p));
      check_all("R11 other slot");
      step(1'b0, 4'd0, 8'd0, 2'(3 - p));
      check_all("R11 hold");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule